// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block computes, for a single word or byte memory transfer, the address presented to memory and the value to write back into the base register. It takes the already decoded addressing bits of the instruction, the base register value, and one of two offset sources: a 12-bit unsigned immediate, or a register value passed through a shifter with an immediate shift amount.

Two index orders are supported. Pre-indexed accesses use base plus or minus offset as the address and may optionally write that same value back. Post-indexed accesses use the unmodified base as the address and always write back the adjusted base. The transfer direction and the byte/word size pass straight through, so the result travels with the address. All results are registered, giving one cycle of latency from a valid request to a valid result.

Top module: `ldst_agu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` and `base_wr_en` are 0.
- R2: With `reg_off`=0, the offset is `imm_off` zero-extended to the address width.
- R3: With `reg_off`=1, the offset is `rm_val` shifted by `shift_amt` as `shift_kind` selects: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. A shift amount of 0 leaves `rm_val` unchanged for every kind.
- R4: With `up`=1 the offset is added to the base. With `up`=0 it is subtracted, modulo 2^32.
- R5: With `pre_idx`=1, `mem_addr` is base±offset, `base_new` equals `mem_addr`, and `base_wr_en` equals `wb_req`.
- R6: With `pre_idx`=0, `mem_addr` is the unmodified base, `base_new` is base±offset, and `base_wr_en` is 1 whatever `wb_req` holds.
- R7: `mem_load` repeats `is_load` (1 = load, 0 = store). `mem_byte` repeats `byte_sel` (1 = byte, 0 = word).
- R8: A request with `in_valid`=1 produces its results, with `out_valid`=1, on the next clock edge. A cycle with `in_valid`=0 gives `out_valid`=0 and `base_wr_en`=0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| reg_off | input | 1 | 1 = shifted register offset, 0 = immediate offset |
| pre_idx | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| up | input | 1 | 1 = add offset, 0 = subtract |
| byte_sel | input | 1 | 1 = byte transfer, 0 = word |
| wb_req | input | 1 | Writeback requested (used when pre-indexed) |
| is_load | input | 1 | 1 = load, 0 = store |
| base | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset |
| rm_val | input | 32 | Offset register value |
| shift_kind | input | 2 | Shift type for register offset |
| shift_amt | input | 5 | Shift amount for register offset |
| out_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Address of the transfer |
| mem_load | output | 1 | Transfer direction |
| mem_byte | output | 1 | Transfer size |
| base_wr_en | output | 1 | Write `base_new` to the base register |
| base_new | output | 32 | Updated base value |

## Verification
The access address and the base update are produced in the same cycle, and the index order decides how they relate. Pre-indexed with writeback must show them equal. Post-indexed must show the address equal to the old base while the update differs from it by the offset. The bench sweeps every pre/up/writeback combination with both offset kinds, every shift type, zero and maximal shift amounts, and subtraction past zero. It checks both outputs in the same sample against its own model, and checks that writeback is forced on post-indexed requests that did not ask for it.

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      reg_off,
  input  logic                      pre_idx,
  input  logic                      up,
  input  logic                      byte_sel,
  input  logic                      wb_req,
  input  logic                      is_load,
  input  logic [ADDR_W-1:0]         base,
  input  logic [IMM_W-1:0]          imm_off,
  input  logic [ADDR_W-1:0]         rm_val,
  input  logic [1:0]                shift_kind,
  input  logic [$clog2(ADDR_W)-1:0] shift_amt,
  output logic                      out_valid,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_load,
  output logic                      mem_byte,
  output logic                      base_wr_en,
  output logic [ADDR_W-1:0]         base_new
);
  localparam int SH_W = $clog2(ADDR_W);

  logic [ADDR_W-1:0]   shifted, offset, adjusted;
  logic [2*ADDR_W-1:0] rot;
  logic [SH_W-1:0]     amt_unused;

  assign amt_unused = shift_amt;
  assign rot = {rm_val, rm_val} >> shift_amt;

  always_comb begin
    case (shift_kind)
      2'b00:   shifted = rm_val << shift_amt;
      2'b01:   shifted = rm_val >> shift_amt;
      2'b10:   shifted = ADDR_W'($signed(rm_val) >>> shift_amt);
      default: shifted = rot[ADDR_W-1:0];
    endcase
  end

  assign offset   = reg_off ? shifted : {{(ADDR_W-IMM_W){1'b0}}, imm_off};
  assign adjusted = up ? base + offset : base - offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      base_wr_en <= 1'b0;
      mem_addr   <= '0;
      base_new   <= '0;
      mem_load   <= 1'b0;
      mem_byte   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      base_wr_en <= in_valid & (wb_req | ~pre_idx);
      mem_addr   <= pre_idx ? adjusted : base;
      base_new   <= adjusted;
      mem_load   <= is_load;
      mem_byte   <= byte_sel;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !base_wr_en);

  p_pre_same_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pre_idx |=> base_new == mem_addr && base_wr_en == $past(wb_req));

  p_post_base_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !pre_idx |=> mem_addr == $past(base) && base_wr_en);

  p_dir_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> mem_load == $past(is_load) && mem_byte == $past(byte_sel));

  p_idle_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !base_wr_en);

  p_zero_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !reg_off && imm_off == '0 |=> base_new == $past(base));

  p_zero_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && reg_off && shift_amt == '0 && up |=> base_new == $past(base) + $past(rm_val));
endmodule

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, reg_off = 1'b0, pre_idx = 1'b0, up = 1'b0;
  logic        byte_sel = 1'b0, wb_req = 1'b0, is_load = 1'b0;
  logic [31:0] base = '0, rm_val = '0;
  logic [11:0] imm_off = '0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic        out_valid, mem_load, mem_byte, base_wr_en;
  logic [31:0] mem_addr, base_new;

  int checks = 0, failures = 0;
  bit done = 0;

  bit          e_valid, e_load, e_byte, e_wb;
  logic [31:0] e_addr, e_new;

  always #10 clk = ~clk;

  ldst_agu dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_off(bit ro, logic [11:0] imm, logic [31:0] rm,
                                          logic [1:0] kind, int amt);
    logic [31:0] v = rm;
    if (!ro) return {20'd0, imm};
    for (int k = 0; k < amt; k++)
      case (kind)
        2'd0: v = v << 1;
        2'd1: v = v >> 1;
        2'd2: v = {v[31], v[31:1]};
        default: v = {v[0], v[31:1]};
      endcase
    return v;
  endfunction

  task automatic drive(bit v, bit ro, bit p, bit u, bit w, bit b, bit l,
                       logic [31:0] bs, logic [11:0] imm, logic [31:0] rm,
                       logic [1:0] kind, logic [4:0] amt);
    logic [31:0] off, adj;
    in_valid = v; reg_off = ro; pre_idx = p; up = u; wb_req = w; byte_sel = b;
    is_load = l; base = bs; imm_off = imm; rm_val = rm; shift_kind = kind; shift_amt = amt;
    off = ref_off(ro, imm, rm, kind, int'(amt));
    adj = u ? bs + off : bs - off;
    e_valid = v; e_load = l; e_byte = b;
    e_wb = v && (w || !p);
    e_addr = p ? adj : bs;
    e_new = adj;
    @(posedge clk);
    @(negedge clk);
    chk("R8 out_valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk("R5/R6/R8 base_wr_en", {31'd0, base_wr_en}, {31'd0, e_wb});
    if (v) begin
      chk(p ? "R5 mem_addr" : "R6 mem_addr", mem_addr, e_addr);
      chk(ro ? "R3/R4 base_new" : "R2/R4 base_new", base_new, e_new);
      chk("R7 mem_load", {31'd0, mem_load}, {31'd0, e_load});
      chk("R7 mem_byte", {31'd0, mem_byte}, {31'd0, e_byte});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 base_wr_en in reset", {31'd0, base_wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 4; a++) begin
          logic [4:0] amt;
          logic [31:0] bs;
          amt = (a == 0) ? 5'd0 : (a == 1) ? 5'd2 : (a == 2) ? 5'd31 : 5'(7 * c + k);
          bs = (a == 3) ? 32'h0000_0010 : 32'h8040_2000 + 32'(c * 4);
          drive(1'b1, c[3], c[2], c[1], c[0], a[0], k[0], bs,
                (a == 1) ? 12'hFFF : (a == 2) ? 12'd0 : 12'd25,
                32'hC000_0F35 ^ 32'(k * 32'h0101_0101), 2'(k), amt);
        end
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h100, 12'd4, 32'd0, 2'd0, 5'd0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h100, 12'd25, 32'd0, 2'd0, 5'd0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h100, 12'd25, 32'd0, 2'd0, 5'd0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h100, 12'd0, 32'h3, 2'd0, 5'd2);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 12'd0, 32'h0, 2'd0, 5'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule